// File: doc/BRIEF.md
# 64-bit Event Timer

This block is a 64-bit event timer reached through a simple 32-bit register port. Software loads a 64-bit period and, if it wishes, a starting count, each as a pair of 32-bit words, and then chooses the run mode. The counter advances once per clock until it matches the period. It then signals an expiry, sets a sticky status flag and, if enabled, asserts an interrupt. In periodic mode the count restarts from zero. In one-shot mode the timer stops and the hardware turns its own mode field off.

Each counter half has its own release bit in a global control register. A half that is not released is held at zero. The count only moves while both halves are released. Reading the low count word captures the upper word in a shadow, so that a low-then-high read pair gives one coherent 64-bit value while the counter runs.

Top module: `evt_timer64`

## Requirements
- R1: After reset every mapped register reads as zero and `irq_o` is low.
- R2: Register map, with byte addresses: count low 0x10, count high 0x14, period low 0x18, period high 0x1C, control 0x20 (all 32 bits stored), global control 0x24 (only bits 1:0 stored, the rest read 0), interrupt control/status 0x44. Any other address reads zero. Read data appears on `bus_rdata` one clock after the read strobe.
- R3: Global control bit 0 releases the low count half and bit 1 releases the high half. A held half reads zero and ignores writes. Counting needs both bits set.
- R4: Control bits 7:6 select the mode: 00 off, 01 one-shot, 10 periodic, 11 behaves as off. While the mode is off the count does not change.
- R5: While running, the 64-bit count rises by exactly one per clock, with a carry from the low word into the high word.
- R6: An expiry occurs in a cycle where the running count equals the period. In periodic mode the count is zero on the next clock and keeps rising, and the mode stays periodic.
- R7: In one-shot mode an expiry leaves the count at the period value. The hardware clears control bits 7:6 to 00 and leaves every other control bit unchanged.
- R8: Status bit 1 is set by an expiry and stays set. Writing 1 to it clears it, and writing 0 leaves it set. A simultaneous expiry wins over the clear.
- R9: Status bit 0 enables the interrupt. `irq_o` is a register that equals flag AND enable as they stood one clock earlier, so it rises two clocks after the expiry cycle.
- R10: A read of the low count word latches the high count word into a shadow. A read of the high count word returns that shadow.
- R11: A write to a released count half takes effect on that clock edge, with priority over counting, and the count continues from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid one clock after `bus_rd` |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume a word-aligned address and that read and write strobes never occur in the same clock. They also assume that any software write to a count half excludes the counting rules for that clock, which is why those rules carry the write strobes in their antecedents. The bench issues exactly one transaction at a time from tasks that change inputs on the falling edge. It loads count halves only while the mode is off, except in the single test of write priority during counting.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  // Register byte offsets; count and period halves step by one bus word.
  localparam int unsigned OFS_CNT  = 'h10;
  localparam int unsigned OFS_PRD  = 'h18;
  localparam int unsigned OFS_CTRL = 'h20;
  localparam int unsigned OFS_GCTL = 'h24;
  localparam int unsigned OFS_INTC = 'h44;

  // Position of the two-bit run mode inside the control word.
  localparam int unsigned MODE_LSB = 6;

  // Interrupt control/status bits.
  localparam int unsigned INTC_EN_BIT   = 0;
  localparam int unsigned INTC_FLAG_BIT = 1;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_ONCE = 2'b01,
    MODE_LOOP = 2'b10,
    MODE_RSVD = 2'b11
  } run_mode_e;

endpackage

// File: rtl/evt_timer_half.sv
module evt_timer_half #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);

  // A held half stays at zero; software load beats reload and increment.
  always_ff @(posedge clk) begin
    if (rst || hold)  q <= '0;
    else if (wr)      q <= wdata;
    else if (clr)     q <= '0;
    else if (inc)     q <= q + W'(1);
  end

endmodule

// File: rtl/evt_timer_irq.sv
module evt_timer_irq import evt_timer_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       expire,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_wdata,
  output logic       int_en,
  output logic       int_flag,
  output logic       irq_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      int_en   <= 1'b0;
      int_flag <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      if (cfg_wr) int_en <= cfg_wdata[INTC_EN_BIT];
      if (expire)                              int_flag <= 1'b1;
      else if (cfg_wr && cfg_wdata[INTC_FLAG_BIT]) int_flag <= 1'b0;
      irq_o <= int_en & int_flag;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    int_flag && !(cfg_wr && cfg_wdata[INTC_FLAG_BIT]) |=> int_flag); // R8

  AST_IRQ_AFTER_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    expire && int_en && !cfg_wr |=> ##1 irq_o); // R9

endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs import evt_timer_pkg::*; #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned CNT_W  = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [BUS_W-1:0]           bus_wdata,
  output logic [BUS_W-1:0]           bus_rdata,
  input  logic [CNT_W-1:0]           cnt,
  input  logic                       expire,
  input  logic                       int_en,
  input  logic                       int_flag,
  output run_mode_e                  mode,
  output logic [CNT_W/BUS_W-1:0]     rel,
  output logic [CNT_W-1:0]           prd,
  output logic [CNT_W/BUS_W-1:0]     cnt_wr,
  output logic                       int_wr
);

  localparam int unsigned NH     = CNT_W / BUS_W;
  localparam int unsigned STRIDE = BUS_W / 8;
  localparam int unsigned SH_W   = CNT_W - BUS_W;

  logic [NH-1:0]    hit_cnt, hit_prd;
  logic             hit_ctrl, hit_gctl, hit_intc;
  logic [BUS_W-1:0] ctrl_q;
  logic [NH-1:0]    gctl_q;
  logic [CNT_W-1:0] prd_q;
  logic [SH_W-1:0]  shadow_q;
  logic [BUS_W-1:0] rd_mux;

  generate
    for (genvar g = 0; g < NH; g++) begin : g_dec
      assign hit_cnt[g] = (bus_addr == ADDR_W'(OFS_CNT + STRIDE * g));
      assign hit_prd[g] = (bus_addr == ADDR_W'(OFS_PRD + STRIDE * g));
    end
  endgenerate

  assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_gctl = (bus_addr == ADDR_W'(OFS_GCTL));
  assign hit_intc = (bus_addr == ADDR_W'(OFS_INTC));

  assign cnt_wr = {NH{bus_wr}} & hit_cnt;
  assign int_wr = bus_wr & hit_intc;
  assign mode   = run_mode_e'(ctrl_q[MODE_LSB +: 2]);
  assign rel    = gctl_q;
  assign prd    = prd_q;

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) rd_mux = ctrl_q;
    if (hit_gctl) rd_mux[NH-1:0] = gctl_q;
    if (hit_intc) begin
      rd_mux[INTC_EN_BIT]   = int_en;
      rd_mux[INTC_FLAG_BIT] = int_flag;
    end
    if (hit_cnt[0]) rd_mux = cnt[BUS_W-1:0];
    for (int i = 1; i < NH; i++)
      if (hit_cnt[i]) rd_mux = shadow_q[(i-1)*BUS_W +: BUS_W];
    for (int i = 0; i < NH; i++)
      if (hit_prd[i]) rd_mux = prd_q[i*BUS_W +: BUS_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      gctl_q    <= '0;
      prd_q     <= '0;
      shadow_q  <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && hit_ctrl)
        ctrl_q <= bus_wdata;
      else if (expire && mode == MODE_ONCE)
        ctrl_q[MODE_LSB +: 2] <= 2'b00;
      if (bus_wr && hit_gctl) gctl_q <= bus_wdata[NH-1:0];
      for (int i = 0; i < NH; i++)
        if (bus_wr && hit_prd[i]) prd_q[i*BUS_W +: BUS_W] <= bus_wdata;
      if (bus_rd && hit_cnt[0]) shadow_q <= cnt[CNT_W-1:BUS_W];
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  AST_ONCE_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    expire && mode == MODE_ONCE && !(bus_wr && hit_ctrl) |=>
      ctrl_q[MODE_LSB +: 2] == 2'b00 &&
      ctrl_q[BUS_W-1:MODE_LSB+2] == $past(ctrl_q[BUS_W-1:MODE_LSB+2]) &&
      ctrl_q[MODE_LSB-1:0] == $past(ctrl_q[MODE_LSB-1:0])); // R7

endmodule

// File: rtl/evt_timer64.sv
module evt_timer64 import evt_timer_pkg::*; #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq_o
);

  localparam int unsigned NH = CNT_W / BUS_W;

  logic [CNT_W-1:0] cnt, prd;
  logic [NH-1:0]    rel, cnt_wr, carry;
  run_mode_e        mode;
  logic             run, expire, step, reload;
  logic             int_wr, int_en, int_flag;

  assign run    = (&rel) && (mode == MODE_ONCE || mode == MODE_LOOP);
  assign expire = run && (cnt == prd);
  assign step   = run && !expire;
  assign reload = expire && (mode == MODE_LOOP);
  assign carry[0] = step;

  generate
    for (genvar g = 0; g < NH; g++) begin : g_half
      if (g + 1 < NH) begin : g_carry
        assign carry[g+1] = carry[g] & (&cnt[g*BUS_W +: BUS_W]);
      end
      evt_timer_half #(.W(BUS_W)) u_half (
        .clk   (clk),
        .rst   (rst),
        .hold  (!rel[g]),
        .wr    (cnt_wr[g]),
        .wdata (bus_wdata),
        .clr   (reload),
        .inc   (carry[g]),
        .q     (cnt[g*BUS_W +: BUS_W])
      );
    end
  endgenerate

  evt_timer_regs #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt       (cnt),
    .expire    (expire),
    .int_en    (int_en),
    .int_flag  (int_flag),
    .mode      (mode),
    .rel       (rel),
    .prd       (prd),
    .cnt_wr    (cnt_wr),
    .int_wr    (int_wr)
  );

  evt_timer_irq u_irq (
    .clk       (clk),
    .rst       (rst),
    .expire    (expire),
    .cfg_wr    (int_wr),
    .cfg_wdata (bus_wdata[1:0]),
    .int_en    (int_en),
    .int_flag  (int_flag),
    .irq_o     (irq_o)
  );

  AST_HELD_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rel[0] |=> cnt[BUS_W-1:0] == '0); // R3

  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (&rel) && !run && !(|cnt_wr) |=> $stable(cnt)); // R4

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    step && !(|cnt_wr) && (&rel) |=> cnt == $past(cnt) + CNT_W'(1)); // R5

  AST_LOOP_RELOAD: assert property (@(posedge clk) disable iff (rst)
    reload && !(|cnt_wr) && (&rel) |=> cnt == '0); // R6

endmodule

// File: tb/test_evt_timer64.sv
`timescale 1ns/1ps
module test_evt_timer64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int          total = 0;
  int          bad = 0;
  int          cyc = 0;
  logic        rd_seen = 1'b0;
  logic        done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] snap_hi;
  int          ce;
  int          ce2;

  localparam int P_LOOP = 20;
  localparam int P_ONCE = 10;

  evt_timer64 i_evt_timer64 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    rd_seen <= bus_rd;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected read data when it is due on the bus.
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk("unexpected read", bus_rdata, 32'hx);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // Count expected at read edge: base plus the edges since enable edge c0.
  task automatic rd_lo_run(input logic [63:0] base, input int c0, input string tag);
    logic [63:0] e;
    @(negedge clk);
    e = base + 64'(cyc - c0);
    bus_rd = 1'b1; bus_addr = 8'h10;
    exp_q.push_back(e[31:0]); tag_q.push_back(tag);
    snap_hi = e[63:32];
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // Reset state
    chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    rd(8'h10, 0, "R1 cnt lo"); rd(8'h14, 0, "R1 cnt hi");
    rd(8'h18, 0, "R1 prd lo"); rd(8'h1C, 0, "R1 prd hi");
    rd(8'h20, 0, "R1 ctrl");   rd(8'h24, 0, "R1 gctl");
    rd(8'h44, 0, "R1 intc");

    // Map and readback
    rd(8'h30, 0, "R2 unmapped");
    wr(8'h18, 32'h1234_5678); wr(8'h1C, 32'h9ABC_DEF0); wr(8'h20, 32'h0000_0F05);
    rd(8'h18, 32'h1234_5678, "R2 prd lo"); rd(8'h1C, 32'h9ABC_DEF0, "R2 prd hi");
    rd(8'h20, 32'h0000_0F05, "R2 ctrl");

    // Held halves ignore writes
    wr(8'h10, 32'h55); rd(8'h10, 0, "R3 held lo write ignored");
    wr(8'h24, 32'hFFFF_FFFF); rd(8'h24, 32'h3, "R2 gctl bits");
    wr(8'h10, 32'h55); wr(8'h14, 32'h66);
    rd(8'h10, 32'h55, "R11 cnt lo load"); rd(8'h14, 32'h66, "R10 cnt hi via shadow");

    // Only low half released: no counting, high half zero
    wr(8'h24, 32'h1); wr(8'h20, 32'h80); idle(5);
    rd(8'h10, 32'h55, "R3 no count with one release");
    rd(8'h10, 32'h55, "R3 lo again"); rd(8'h14, 0, "R3 hi held zero");
    wr(8'h20, 32'h0);

    // Mode 11 acts as off
    wr(8'h24, 32'h3); wr(8'h10, 32'h10); wr(8'h14, 32'h0);
    wr(8'h20, 32'hC0); idle(5);
    rd(8'h10, 32'h10, "R4 mode 11 holds"); rd(8'h20, 32'hC0, "R4 ctrl");
    wr(8'h20, 32'h0); idle(3);
    rd(8'h10, 32'h10, "R4 mode 00 holds");

    // Counting with carry, snapshot
    wr(8'h10, 32'hFFFF_FFFC); wr(8'h14, 32'h7);
    wr(8'h18, 32'hFFFF_FFFF); wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h20, 32'h80); ce = cyc;
    rd_lo_run(64'h7_FFFF_FFFC, ce, "R5 count lo");
    rd(8'h14, snap_hi, "R10 shadow before carry");
    idle(3);
    rd_lo_run(64'h7_FFFF_FFFC, ce, "R5 count lo after carry");
    rd(8'h14, snap_hi, "R10 shadow after carry");
    wr(8'h20, 32'h0);

    // Periodic expiry and interrupt
    wr(8'h44, 32'h1);
    wr(8'h10, 32'h0); wr(8'h14, 32'h0);
    wr(8'h18, P_LOOP); wr(8'h1C, 32'h0);
    wr(8'h20, 32'h80); ce = cyc;
    while (cyc != ce + P_LOOP + 1) @(negedge clk);
    chk("R9 irq low at flag edge", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R9 irq high one clock later", {31'b0, irq_o}, 32'h1);
    rd_lo_run(64'h0, ce + P_LOOP + 1, "R6 count after reload");
    rd(8'h44, 32'h3, "R8 flag set"); rd(8'h20, 32'h80, "R6 mode kept");
    wr(8'h20, 32'h0);
    wr(8'h44, 32'h1); rd(8'h44, 32'h3, "R8 write 0 keeps flag");
    wr(8'h44, 32'h3); rd(8'h44, 32'h1, "R8 write 1 clears flag");
    chk("R9 irq drops", {31'b0, irq_o}, 32'h0);

    // One-shot
    wr(8'h44, 32'h0);
    wr(8'h10, 32'h0); wr(8'h14, 32'h0);
    wr(8'h18, P_ONCE); wr(8'h1C, 32'h0);
    wr(8'h20, 32'h141); idle(20);
    rd(8'h20, 32'h101, "R7 mode self-cleared");
    rd(8'h10, P_ONCE, "R7 count holds at period");
    rd(8'h44, 32'h2, "R8 flag from one-shot");
    chk("R9 irq masked", {31'b0, irq_o}, 32'h0);

    // Write priority while running, then hold by release bits
    wr(8'h10, 32'h0); wr(8'h14, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF); wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h20, 32'h80); idle(3);
    wr(8'h10, 32'h1000); ce2 = cyc;
    rd_lo_run(64'h1000, ce2, "R11 load while running");
    wr(8'h24, 32'h0);
    rd(8'h10, 0, "R3 released bits cleared"); idle(3);
    rd(8'h10, 0, "R3 stays held"); rd(8'h20, 32'h80, "R3 mode untouched");

    idle(3);
    if (exp_q.size() != 0) chk("R2 pending reads", exp_q.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule